// File: doc/BRIEF.md
# Four-Lane Seven-Slot Word Deserializer

This block turns four serial data lanes plus a forwarded frame-clock lane into one 28-bit parallel word per frame. All lanes are sampled on one bit clock that runs at seven times the frame rate. The forwarded clock lane is high for four bit slots and low for three. The first high sample after a low one marks slot 0 of a new frame. Each lane carries seven bits per frame, with slot 0 earliest in time. Each completed frame is loaded into a registered output word. An output word clock falls as the word changes and rises in the middle of the stable window, so downstream logic can strobe the data on the rising edge.

The block also covers the quiet and abnormal input conditions:

- **Power-down:** an active-low input forces every output low.
- **Idle data lanes:** failsafe biasing holds idle data lanes high. While the clock lane still toggles, this gives an all-ones word.
- **Stopped clock lane:** if the clock lane stops toggling, the last word is held and the word clock parks high.
- **Recovery:** after reset, power-down or a stop, the first frame edge only re-arms the capture path.

Top module: `sdes7_rx`

## Requirements
- R1: Output bit 7k+j equals the bit that lane k carried in slot j of the frame, with k from 0 to 3 and j from 0 to 6. Slot 0 is the first slot in time.
- R2: Slot 0 of a frame is the first bit-clock sample in which the clock lane reads 1 after reading 0. The captured word is always the seven samples taken just before that slot 0, so an inserted extra bit period shifts that one word and the next word is aligned again.
- R3: A frame's word appears on word_out two bit-clock edges after slot 0 of the following frame is sampled. word_out does not change at any other time, except through power-down.
- R4: In steady running, word_clk goes low on the edge that loads a new word. It stays low for 3 bit periods and then stays high for 4 bit periods.
- R5: While pd_n is 0, word_out is all zeros and word_clk is 0 from the next bit-clock edge onward.
- R6: With the clock lane toggling and every data lane held at 1, the word read out is all ones.
- R7: If no frame edge is seen for 14 bit periods (two frames), word_out holds its last value and word_clk is driven high. Data lane activity during that time has no effect.
- R8: After reset, after power-down, or after the clock lane has been declared stopped, the first frame edge only re-arms the capture path. The word it would have loaded is discarded, and word_out keeps its value until the next frame edge.
- R9: While rst is 1, word_out is all zeros and word_clk is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, seven cycles per frame |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Power-down, active low; outputs forced low |
| fclk_in | input | 1 | Forwarded frame-clock lane, 4 slots high then 3 low |
| lane_in | input | 4 | Serial data lanes, one bit per slot each |
| word_out | output | 28 | Reassembled parallel word |
| word_clk | output | 1 | Output word clock; rising edge strobes word_out |

## Verification
The in-module assertions check the following on every cycle:

- power-down forces both outputs low;
- word_out never moves without a capture;
- word_out holds, and word_clk sits high, once the clock lane is declared stopped;
- word_clk falls on every load;
- the capture path can only become armed through a frame edge.

Only the bench's scenarios can show the following:

- the lane-and-slot bit mapping and the exact load latency;
- the all-ones result of idle-high data lanes;
- the realignment after a slipped bit period;
- the discarded first frame after each recovery.

// File: rtl/sdes7_pkg.sv
package sdes7_pkg;
  localparam int DEF_LANES       = 4;
  localparam int DEF_SLOTS       = 7;
  localparam int DEF_STOP_FRAMES = 2;

  // first phase value at which the word clock is high: low for floor(S/2) slots
  function automatic int wclk_high_from(input int slots);
    return slots / 2;
  endfunction
endpackage

// File: rtl/sdes7_lane.sv
module sdes7_lane #(
  parameter int SLOTS = sdes7_pkg::DEF_SLOTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [SLOTS-1:0] slots
);
  logic d_q;

  // newest sample enters at the top; after SLOTS shifts slots[0] is the oldest
  always_ff @(posedge clk) begin
    if (rst) begin
      d_q   <= 1'b0;
      slots <= '0;
    end else begin
      d_q   <= din;
      slots <= {d_q, slots[SLOTS-1:1]};
    end
  end
endmodule

// File: rtl/sdes7_frame.sv
module sdes7_frame #(
  parameter int SLOTS       = sdes7_pkg::DEF_SLOTS,
  parameter int STOP_FRAMES = sdes7_pkg::DEF_STOP_FRAMES,
  parameter int PH_W        = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pd_n,
  input  logic            fclk_in,
  output logic            capture,
  output logic            stopped,
  output logic [PH_W-1:0] ph
);
  localparam int STOP_CYC = SLOTS * STOP_FRAMES;
  localparam int GAP_W    = $clog2(STOP_CYC + 1);

  logic             ck_q;
  logic             ck_prev;
  logic             armed;
  logic [GAP_W-1:0] gap;
  logic             frame_edge;

  assign frame_edge = ck_q & ~ck_prev;
  assign stopped    = (gap == GAP_W'(STOP_CYC));
  assign capture    = frame_edge & armed & ~stopped;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q    <= 1'b0;
      ck_prev <= 1'b0;
      gap     <= '0;
      ph      <= '0;
      armed   <= 1'b0;
    end else begin
      ck_q    <= fclk_in;
      ck_prev <= ck_q;
      if (frame_edge)   gap <= '0;
      else if (!stopped) gap <= gap + GAP_W'(1);
      if (frame_edge)                      ph <= PH_W'(1);
      else if (ph != PH_W'(SLOTS - 1))     ph <= ph + PH_W'(1);
      armed <= pd_n & (frame_edge | (armed & ~stopped));
    end
  end

  // R7: a frame edge always restarts the stop timer
  p_edge_clears_stop_r7: assert property (@(posedge clk) disable iff (rst)
    frame_edge |=> !stopped);

  // R8: the capture path becomes armed only through a frame edge
  p_arm_needs_edge_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(frame_edge));
endmodule

// File: rtl/sdes7_out.sv
module sdes7_out #(
  parameter int WORD_W = sdes7_pkg::DEF_LANES * sdes7_pkg::DEF_SLOTS,
  parameter int SLOTS  = sdes7_pkg::DEF_SLOTS,
  parameter int PH_W   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_n,
  input  logic              capture,
  input  logic              stopped,
  input  logic [PH_W-1:0]   ph,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out,
  output logic              word_clk
);
  localparam int HIGH_FROM = sdes7_pkg::wclk_high_from(SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_clk <= 1'b0;
    end else if (!pd_n) begin
      word_out <= '0;
      word_clk <= 1'b0;
    end else if (capture) begin
      word_out <= word_in;
      word_clk <= 1'b0;
    end else if (stopped) begin
      word_clk <= 1'b1;
    end else begin
      word_clk <= (ph >= PH_W'(HIGH_FROM));
    end
  end

  // R5: power-down drives every output low on the next edge
  p_pd_low_r5: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (word_out == '0) && !word_clk);

  // R3: the word only moves on a capture
  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (pd_n && !capture) |=> $stable(word_out));

  // R4: loading a word pulls the word clock low
  p_wclk_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (pd_n && capture) |=> !word_clk);

  // R7: stopped clock lane parks the word clock high
  p_wclk_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (pd_n && stopped && !capture) |=> word_clk);
endmodule

// File: rtl/sdes7_rx.sv
module sdes7_rx #(
  parameter int LANES       = sdes7_pkg::DEF_LANES,
  parameter int SLOTS       = sdes7_pkg::DEF_SLOTS,
  parameter int STOP_FRAMES = sdes7_pkg::DEF_STOP_FRAMES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pd_n,
  input  logic                   fclk_in,
  input  logic [LANES-1:0]       lane_in,
  output logic [LANES*SLOTS-1:0] word_out,
  output logic                   word_clk
);
  localparam int WORD_W = LANES * SLOTS;
  localparam int PH_W   = $clog2(SLOTS);

  logic [WORD_W-1:0] word_asm;
  logic              capture;
  logic              stopped;
  logic [PH_W-1:0]   ph;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SLOTS-1:0] slots;
    sdes7_lane #(.SLOTS(SLOTS)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .din   (lane_in[k]),
      .slots (slots)
    );
    // lane k, slot j -> bit k*SLOTS + j
    assign word_asm[k*SLOTS +: SLOTS] = slots;
  end

  sdes7_frame #(.SLOTS(SLOTS), .STOP_FRAMES(STOP_FRAMES), .PH_W(PH_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .pd_n    (pd_n),
    .fclk_in (fclk_in),
    .capture (capture),
    .stopped (stopped),
    .ph      (ph)
  );

  sdes7_out #(.WORD_W(WORD_W), .SLOTS(SLOTS), .PH_W(PH_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .pd_n     (pd_n),
    .capture  (capture),
    .stopped  (stopped),
    .ph       (ph),
    .word_in  (word_asm),
    .word_out (word_out),
    .word_clk (word_clk)
  );
endmodule

// File: tb/sdes7_rx_tb.sv
module sdes7_rx_tb;
  localparam int LANES = 4;
  localparam int SLOTS = 7;
  localparam int W     = LANES * SLOTS;
  localparam int NVEC  = 8;
  localparam logic [W-1:0] VEC [0:NVEC-1] = '{
    28'h0000000, 28'h5555555, 28'hFFFFFFF, 28'hAAAAAAA,
    28'h0000001, 28'h8000000, 28'h1234567, 28'hFEDCBA9};

  logic clk = 1'b0;
  logic rst, pd_n, fclk_in;
  logic [LANES-1:0] lane_in;
  logic [W-1:0] word_out;
  logic word_clk;
  int total = 0;
  int bad   = 0;
  logic [W-1:0] prev_out = '0;

  always #10 clk = ~clk;

  sdes7_rx u_dut (
    .clk(clk), .rst(rst), .pd_n(pd_n), .fclk_in(fclk_in),
    .lane_in(lane_in), .word_out(word_out), .word_clk(word_clk));

  task automatic chk_word(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s word actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s word_clk actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] slip1(input logic [W-1:0] x);
    logic [W-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*SLOTS +: SLOTS] = {1'b0, x[k*SLOTS+1 +: SLOTS-1]};
    return r;
  endfunction

  // drives one frame; checks the word loaded by this frame's edge
  task automatic send_frame(input logic [W-1:0] w, input logic [W-1:0] exp,
                            input logic clk_chk, input string req);
    for (int j = 0; j < SLOTS; j++) begin
      @(negedge clk);
      if (j == 1) chk_word(word_out, prev_out, "R3");
      if (j == 2) begin
        chk_word(word_out, exp, req);
        prev_out = exp;
        if (clk_chk) chk_bit(word_clk, 1'b0, "R4");
      end
      if (j == 4 && clk_chk) chk_bit(word_clk, 1'b0, "R4");
      if (j == 5 && clk_chk) chk_bit(word_clk, 1'b1, "R4");
      fclk_in = (j < 4);
      for (int k = 0; k < LANES; k++) lane_in[k] = w[k*SLOTS + j];
    end
  endtask

  task automatic idle(input int n, input logic ck, input logic [LANES-1:0] d);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fclk_in = ck;
      lane_in = d;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; pd_n = 1'b1; fclk_in = 1'b0; lane_in = '0;
    repeat (5) @(negedge clk);
    chk_word(word_out, '0, "R9");
    chk_bit(word_clk, 1'b0, "R9");
    rst = 1'b0;

    // vector table: first edge arms only (R8), then each frame shows the one before
    for (int i = 0; i < NVEC; i++) begin
      if (i == 0) send_frame(VEC[0], '0, 1'b0, "R8");
      else send_frame(VEC[i], VEC[i-1], 1'b1, (VEC[i-1] == '1) ? "R6" : "R1");
    end

    // R2: one extra bit period before the next frame
    idle(1, 1'b0, '0);
    send_frame(28'h2468ACE, slip1(VEC[NVEC-1]), 1'b1, "R2");
    send_frame(28'h1357BDF, 28'h2468ACE, 1'b1, "R2");

    // R7: clock lane and data lanes go idle high; the entry edge loads the last frame
    idle(20, 1'b1, '1);
    @(negedge clk);
    chk_word(word_out, 28'h1357BDF, "R7");
    chk_bit(word_clk, 1'b1, "R7");
    prev_out = 28'h1357BDF;

    // R8: resume; first real edge (frame B) only re-arms
    send_frame(28'h0F0F0F0, 28'h1357BDF, 1'b0, "R8");
    send_frame(28'h3C3C3C3, 28'h1357BDF, 1'b0, "R8");
    send_frame(28'h7777777, 28'h3C3C3C3, 1'b1, "R8");
    send_frame(28'h0000000, 28'h7777777, 1'b1, "R1");

    // R5: power-down
    @(negedge clk);
    pd_n = 1'b0; fclk_in = 1'b0; lane_in = '1;
    idle(3, 1'b0, '1);
    chk_word(word_out, '0, "R5");
    chk_bit(word_clk, 1'b0, "R5");
    idle(4, 1'b0, '1);
    chk_word(word_out, '0, "R5");
    chk_bit(word_clk, 1'b0, "R5");
    prev_out = '0;
    pd_n = 1'b1;
    send_frame(28'hABCDEF0, '0, 1'b0, "R8");
    send_frame(28'h0123456, 28'hABCDEF0, 1'b1, "R5");
    send_frame(28'h5A5A5A5, 28'h0123456, 1'b1, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule